// File: doc/BRIEF.md
# Relocatable Peripheral Register Window

This block claims a 256-byte page of a 16-bit I/O address space for a group of peripheral control registers. The page is chosen by a relocation register that is itself one of the registers inside the page. A bus master moves the page by writing the relocation register. From then on, every access is decoded against the new page. When an access falls inside the page, the block raises a chip select during the strobe cycle and raises ready on the cycle after. It also supplies read data and updates its registers. When an access falls outside the page, the block stays silent and leaves the bus cycle to an external ready source.

The registers hold full 16-bit values while the external bus may be only 8 bits wide. The size input marks each strobe as a byte cycle or a word cycle. The page decodes three locations: two general 16-bit example registers and the relocation register. All other offsets are reserved. The relocation register updates on the edge that ends its write strobe. So when a word write to it is split into two byte cycles, the second cycle already misses the page.

Top module: `periphWindowDecoder`

## Requirements
- R1: After reset the relocation value is 00FFh, so the page covers FF00h..FFFFh. Both example registers read 0000h and ready is low.
- R2: `csOut` is high in a cycle exactly when a read or write strobe is present and address bits [15:8] equal the low byte of the relocation register.
- R3: `readyOut` is high in the cycle after every strobe that hit the page, including hits on reserved offsets and odd offsets. It is low after a strobe that missed.
- R4: A write of either size at even offset 00h (register A) or 02h (register B) loads all 16 bits of `busWrData` into that register.
- R5: A write of either size at even offset FEh loads all 16 bits of `busWrData` into the relocation register. The next strobe is decoded against the new page.
- R6: When a word write to the relocation register is split into a byte cycle at FEh followed by a byte cycle at FFh, the second cycle gets neither chip select nor ready, because the page has already moved.
- R7: A write to a reserved offset (any offset other than 00h to 03h and FEh to FFh) changes no register, and a read of a reserved offset returns 0000h.
- R8: Any write at an odd offset inside the page completes with ready but leaves every register unchanged.
- R9: Read data appears on `busRdData` in the ready cycle, and is 0000h in every other cycle. A word read returns the full register. A byte read returns the low byte (even offset) or the high byte (odd offset) in bits [7:0], with bits [15:8] zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | I/O address of the current strobe |
| busWrData | input | 16 | Internal 16-bit write value |
| busRd | input | 1 | Read strobe, one cycle per bus cycle |
| busWr | input | 1 | Write strobe, one cycle per bus cycle |
| busByte | input | 1 | 1 = byte cycle, 0 = word cycle |
| csOut | output | 1 | Page hit during a strobe |
| readyOut | output | 1 | Internal ready, one cycle after a hit |
| busRdData | output | 16 | Read data, valid with ready |
| exRegA | output | 16 | Example register at offset 00h |
| exRegB | output | 16 | Example register at offset 02h |
| relocValue | output | 16 | Current relocation register |

## Verification
Several rules are checked by assertions on every cycle:
- Ready follows each hit and is absent after each miss.
- Odd-offset writes raise no write strobe.
- Registers hold whenever their write strobe is idle.
- Read data is zero outside a read.

Other behaviour can only be shown by bench scenarios:
- The reset value of the relocation register.
- That a byte write loads all 16 bits.
- That reserved offsets read back zero after being written.
- That the second half of a split relocation write misses the moved page.

// File: rtl/periphWinPkg.sv
package periphWinPkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_A     = 2'd1,
    SEL_B     = 2'd2,
    SEL_RELOC = 2'd3
  } rdSelT;

  typedef struct packed {
    logic  wrA;
    logic  wrB;
    logic  wrReloc;
    logic  rdEn;
    logic  rdByte;
    logic  rdHigh;
    rdSelT rdSel;
  } winStrobeT;

endpackage

// File: rtl/periphWinCtrl.sv
module periphWinCtrl
  import periphWinPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 8,
  parameter logic [OFFS_W-1:0] OFF_A     = 'h00,
  parameter logic [OFFS_W-1:0] OFF_B     = 'h02,
  parameter logic [OFFS_W-1:0] OFF_RELOC = 'hFE,
  localparam int PAGE_W = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              busByte,
  input  logic [PAGE_W-1:0] pageBase,
  output logic              csOut,
  output logic              readyOut,
  output winStrobeT         strobes
);

  logic              strobeAny;
  logic              pageHit;
  logic [OFFS_W-1:0] offset;
  logic [OFFS_W-1:0] wordOff;

  assign strobeAny = busRd | busWr;
  assign pageHit   = (busAddr[ADDR_W-1:OFFS_W] == pageBase);
  assign offset    = busAddr[OFFS_W-1:0];
  assign wordOff   = {offset[OFFS_W-1:1], 1'b0};
  assign csOut     = strobeAny & pageHit;

  always_comb begin
    strobes       = '0;
    strobes.rdSel = SEL_NONE;
    if (csOut) begin
      if (busWr && !offset[0]) begin
        if (offset == OFF_A)     strobes.wrA     = 1'b1;
        if (offset == OFF_B)     strobes.wrB     = 1'b1;
        if (offset == OFF_RELOC) strobes.wrReloc = 1'b1;
      end
      if (busRd) begin
        strobes.rdEn   = 1'b1;
        strobes.rdByte = busByte;
        strobes.rdHigh = busByte & offset[0];
        if (wordOff == OFF_A)          strobes.rdSel = SEL_A;
        else if (wordOff == OFF_B)     strobes.rdSel = SEL_B;
        else if (wordOff == OFF_RELOC) strobes.rdSel = SEL_RELOC;
        else                           strobes.rdSel = SEL_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) readyOut <= 1'b0;
    else       readyOut <= csOut;
  end

  // R3: every hit is followed by ready
  p_ready_after_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobeAny && pageHit) |=> readyOut);

  // R6: a strobe outside the page never gets internal ready
  p_no_ready_on_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobeAny && !pageHit) |=> !readyOut);

  // R8: odd-offset writes raise no register write strobe
  p_odd_write_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[0]) |-> !(strobes.wrA || strobes.wrB || strobes.wrReloc));

  // R4: at most one register written per strobe
  p_single_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrA, strobes.wrB, strobes.wrReloc}));

endmodule

// File: rtl/periphWinData.sv
module periphWinData
  import periphWinPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAGE_W = 8,
  parameter logic [DATA_W-1:0] RESET_RELOC = 'h00FF,
  localparam int HALF = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobeT         strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] relocReg,
  output logic [PAGE_W-1:0] pageBase
);

  logic [DATA_W-1:0] selValue;
  logic [DATA_W-1:0] laneValue;

  assign pageBase = relocReg[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA     <= '0;
      regB     <= '0;
      relocReg <= RESET_RELOC;
    end else begin
      if (strobes.wrA)     regA     <= wrData;
      if (strobes.wrB)     regB     <= wrData;
      if (strobes.wrReloc) relocReg <= wrData;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      SEL_A:     selValue = regA;
      SEL_B:     selValue = regB;
      SEL_RELOC: selValue = relocReg;
      default:   selValue = '0;
    endcase
    if (!strobes.rdByte)    laneValue = selValue;
    else if (strobes.rdHigh) laneValue = {{HALF{1'b0}}, selValue[DATA_W-1:HALF]};
    else                     laneValue = {{HALF{1'b0}}, selValue[HALF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= '0;
    else if (strobes.rdEn)  rdData <= laneValue;
    else                    rdData <= '0;
  end

  // R7: registers hold unless their own strobe fires
  p_rega_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrA |=> $stable(regA));
  p_regb_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrB |=> $stable(regB));

  // R5: the relocation value changes only on its own write
  p_reloc_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrReloc |=> $stable(relocReg));

  // R9: read data is zero outside a read
  p_rd_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |=> (rdData == '0));

endmodule

// File: rtl/periphWindowDecoder.sv
module periphWindowDecoder
  import periphWinPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int OFFS_W = 8,
  parameter logic [DATA_W-1:0] RESET_RELOC = 'h00FF,
  localparam int PAGE_W = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              busByte,
  output logic              csOut,
  output logic              readyOut,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] exRegA,
  output logic [DATA_W-1:0] exRegB,
  output logic [DATA_W-1:0] relocValue
);

  winStrobeT         strobes;
  logic [PAGE_W-1:0] pageBase;

  periphWinCtrl #(
    .ADDR_W(ADDR_W),
    .OFFS_W(OFFS_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWr    (busWr),
    .busByte  (busByte),
    .pageBase (pageBase),
    .csOut    (csOut),
    .readyOut (readyOut),
    .strobes  (strobes)
  );

  periphWinData #(
    .DATA_W     (DATA_W),
    .PAGE_W     (PAGE_W),
    .RESET_RELOC(RESET_RELOC)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .regA     (exRegA),
    .regB     (exRegB),
    .relocReg (relocValue),
    .pageBase (pageBase)
  );

endmodule

// File: tb/tb_periphWindowDecoder.sv
module tb_periphWindowDecoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [15:0] busWrData = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic        busByte = 1'b0;
  logic        csOut, readyOut;
  logic [15:0] busRdData, exRegA, exRegB, relocValue;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  periphWindowDecoder dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busRd(busRd), .busWr(busWr), .busByte(busByte), .csOut(csOut),
    .readyOut(readyOut), .busRdData(busRdData), .exRegA(exRegA),
    .exRegB(exRegB), .relocValue(relocValue)
  );

  // {req[3:0], rd, wr, byte, addr[15:0], data[15:0], expCs, expRdy, expRd[15:0]}
  localparam int NV = 14;
  localparam logic [56:0] VEC [NV] = '{
    {4'd4, 1'b0, 1'b1, 1'b0, 16'hFF00, 16'h1234, 1'b1, 1'b1, 16'h0000}, // R4 word write A
    {4'd4, 1'b1, 1'b0, 1'b0, 16'hFF00, 16'h0000, 1'b1, 1'b1, 16'h1234}, // R4 read A
    {4'd4, 1'b0, 1'b1, 1'b1, 16'hFF02, 16'hABCD, 1'b1, 1'b1, 16'h0000}, // R4 byte write B, full 16
    {4'd4, 1'b1, 1'b0, 1'b0, 16'hFF02, 16'h0000, 1'b1, 1'b1, 16'hABCD}, // R4 read B
    {4'd9, 1'b1, 1'b0, 1'b1, 16'hFF02, 16'h0000, 1'b1, 1'b1, 16'h00CD}, // R9 byte read low
    {4'd9, 1'b1, 1'b0, 1'b1, 16'hFF03, 16'h0000, 1'b1, 1'b1, 16'h00AB}, // R9 byte read high
    {4'd8, 1'b0, 1'b1, 1'b1, 16'hFF03, 16'h5555, 1'b1, 1'b1, 16'h0000}, // R8 odd write
    {4'd8, 1'b1, 1'b0, 1'b0, 16'hFF02, 16'h0000, 1'b1, 1'b1, 16'hABCD}, // R8 B unchanged
    {4'd7, 1'b0, 1'b1, 1'b0, 16'hFF10, 16'h9999, 1'b1, 1'b1, 16'h0000}, // R7 reserved write
    {4'd7, 1'b1, 1'b0, 1'b0, 16'hFF10, 16'h0000, 1'b1, 1'b1, 16'h0000}, // R7 reserved reads zero
    {4'd2, 1'b1, 1'b0, 1'b0, 16'h1200, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R2 miss read
    {4'd3, 1'b0, 1'b1, 1'b0, 16'h1202, 16'h7777, 1'b0, 1'b0, 16'h0000}, // R3 miss write
    {4'd3, 1'b1, 1'b0, 1'b0, 16'hFF02, 16'h0000, 1'b1, 1'b1, 16'hABCD}, // R3 miss wrote nothing
    {4'd1, 1'b1, 1'b0, 1'b0, 16'hFFFE, 16'h0000, 1'b1, 1'b1, 16'h00FF}  // R1 reset relocation
  };

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic busCycle(input logic rd, input logic wr, input logic byt,
                          input logic [15:0] addr, input logic [15:0] data,
                          output logic cs, output logic rdy, output logic [15:0] rdv);
    @(negedge clk);
    busRd = rd; busWr = wr; busByte = byt; busAddr = addr; busWrData = data;
    #1 cs = csOut;
    @(negedge clk);
    rdy = readyOut;
    rdv = busRdData;
    busRd = 1'b0; busWr = 1'b0;
  endtask

  task automatic expectCycle(input string tag, input logic rd, input logic wr,
                             input logic byt, input logic [15:0] addr,
                             input logic [15:0] data, input logic eCs,
                             input logic eRdy, input logic [15:0] eRd);
    logic cs, rdy;
    logic [15:0] rdv;
    busCycle(rd, wr, byt, addr, data, cs, rdy, rdv);
    check(tag, "cs", {15'd0, cs}, {15'd0, eCs});
    check(tag, "ready", {15'd0, rdy}, {15'd0, eRdy});
    check(tag, "rdData", rdv, eRd);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "reloc", relocValue, 16'h00FF);
    check("R1", "regA", exRegA, 16'h0000);
    check("R1", "regB", exRegB, 16'h0000);
    check("R1", "ready", {15'd0, readyOut}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[56:53]);
      expectCycle(tag, v[52], v[51], v[50], v[49:34], v[33:18], v[17], v[16], v[15:0]);
    end

    // R5: byte write to relocation loads all 16 bits, page moves to 12xx
    expectCycle("R5", 1'b0, 1'b1, 1'b1, 16'hFFFE, 16'h3412, 1'b1, 1'b1, 16'h0000);
    check("R5", "reloc", relocValue, 16'h3412);
    expectCycle("R5", 1'b1, 1'b0, 1'b0, 16'h12FE, 16'h0000, 1'b1, 1'b1, 16'h3412);
    expectCycle("R5", 1'b1, 1'b0, 1'b0, 16'hFF00, 16'h0000, 1'b0, 1'b0, 16'h0000);
    expectCycle("R2", 1'b1, 1'b0, 1'b0, 16'h1200, 16'h0000, 1'b1, 1'b1, 16'h1234);

    // R6: split word write, first byte moves the page, second byte misses
    expectCycle("R6", 1'b0, 1'b1, 1'b1, 16'h12FE, 16'h0040, 1'b1, 1'b1, 16'h0000);
    expectCycle("R6", 1'b0, 1'b1, 1'b1, 16'h12FF, 16'h0040, 1'b0, 1'b0, 16'h0000);
    check("R6", "reloc", relocValue, 16'h0040);
    expectCycle("R6", 1'b1, 1'b0, 1'b0, 16'h40FE, 16'h0000, 1'b1, 1'b1, 16'h0040);
    expectCycle("R4", 1'b1, 1'b0, 1'b0, 16'h4002, 16'h0000, 1'b1, 1'b1, 16'hABCD);

    // R8: odd write at relocation high byte leaves everything unchanged
    expectCycle("R8", 1'b0, 1'b1, 1'b0, 16'h40FF, 16'hFFFF, 1'b1, 1'b1, 16'h0000);
    check("R8", "reloc", relocValue, 16'h0040);
    check("R8", "regA", exRegA, 16'h1234);

    // R9: read data drops back to zero after the ready cycle
    @(negedge clk);
    check("R9", "idle rdData", busRdData, 16'h0000);
    check("R3", "idle ready", {15'd0, readyOut}, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule